// File: doc/BRIEF.md
# UART Receive Byte Queue

This block is the receive-side byte store of a serial port. Bytes enter from one of three places: the line receiver, a break indication that stores a zero byte, or the transmit data write path when the port is looped back internally. A two-bit channel mode picks the source. The host drains the queue one byte at a time. Each read strobe removes the oldest byte and shows the byte that follows it.

A small control word turns reception on or off. It also flushes the queue. Status outputs give the fill count, empty and full flags, and a flag that is raised when the count reaches a programmable threshold. Two one-cycle event pulses report lost bytes and receive inactivity. The inactivity timer runs for four character times after the last accepted byte. The length of a character follows the frame settings held in the mode word.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the count is 0, `empty` is 1, `full` and `trigger` are 0, both event pulses are 0, and reception is off (enable bit clear, disable bit set).
- R2: Reception is on only when control bit 2 (enable) is 1 and control bit 3 (disable) is 0. A write to the control word with `ctrlWrEn` loads both bits. While reception is off, incoming bytes and read strobes leave the count unchanged, and `rdData` reads 0.
- R3: Bytes leave in arrival order. `count` tracks the stored bytes, and the queue holds up to DEPTH (64) bytes. `full` is 1 exactly at DEPTH, and `empty` is 1 exactly at 0. A push and a pop in the same cycle both take effect.
- R4: A byte that arrives while the queue is full is discarded. `overrunPulse` is then 1 for the single cycle that follows the clock edge of the attempt.
- R5: While reception is on, `rdData` shows the oldest byte, or 0 when the queue is empty. A read strobe on an empty queue changes nothing.
- R6: `trigger` is 1 whenever the count is greater than or equal to the threshold register. The threshold is written through `trigWrEn`, and its value after reset is 32.
- R7: Writing the control word with bit 0 set empties the queue at that clock edge. This bit is not stored, so later control writes without it do not flush.
- R8: The channel mode is mode bits 9:8. Modes 0 and 1 take bytes from `rxValid`/`rxData`. Mode 2 takes bytes from `txWrEn`/`txWrData`. Mode 3 takes neither.
- R9: A `rxBreak` strobe stores the byte 0x00, in any channel mode.
- R10: Each accepted byte loads a timer with 4 × character clocks. With L as the loaded value, `timeoutPulse` is 1 in the cycle that follows the L-th clock edge after the accepting edge, provided no byte is accepted in between and the timeout register (`toutWrData`) is nonzero. When the timeout register is zero, no pulse is raised.
- R11: Character clocks equal `bitClocks` × (1 + data bits + parity bit + stop bits). The data bits are 6 when mode bits 2:1 are 3, 7 when they are 2, and 8 otherwise. The parity bit counts when mode bits 5:3 are 0 or 1. There is 1 stop bit when mode bits 7:6 are 3, and 2 stop bits otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 4 | Bit 0 flush, bit 2 enable, bit 3 disable |
| modeWrEn | input | 1 | Mode word write strobe |
| modeWrData | input | 10 | Frame settings and channel mode (bits 9:8) |
| trigWrEn | input | 1 | Threshold write strobe |
| trigWrData | input | 7 | Threshold value |
| toutWrEn | input | 1 | Timeout register write strobe |
| toutWrData | input | 8 | Timeout register, nonzero arms the timeout |
| bitClocks | input | 12 | Clock cycles per serial bit |
| rxValid | input | 1 | Byte from the line receiver |
| rxData | input | 8 | Received byte |
| rxBreak | input | 1 | Break seen on the line |
| txWrEn | input | 1 | Transmit data register write |
| txWrData | input | 8 | Transmit data byte |
| rdEn | input | 1 | Pop strobe |
| rdData | output | 8 | Oldest byte, or 0 |
| count | output | 7 | Bytes stored |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| trigger | output | 1 | Count at or above threshold |
| overrunPulse | output | 1 | A byte was lost |
| timeoutPulse | output | 1 | Receive inactivity event |

## Verification
`rdData` is combinational. The bench reads it after driving the inputs on the falling edge and before the rising edge that acts on them. Count, flags and both event pulses are registered and change at the rising edge that samples the stimulus. The bench checks them on the following falling edge, against a queue model that is updated with the values from before that edge. The timeout is due L rising edges after the accepting edge, where L is 4 × character clocks. The bench counts idle cycles from the push and requires the pulse in exactly that cycle and in no other.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic       push;
    logic       pop;
    logic       flush;
    logic [7:0] pushByte;
  } qStrobe_t;
endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  qStrobe_t      stb,
  output logic [7:0]    headByte,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) wrPtr <= nextPtr(wrPtr);
      if (stb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({stb.push, stb.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push && !stb.flush) mem[wrPtr] <= stb.pushByte;
  end

  assign headByte = mem[rdPtr];
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  assert_no_push_when_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> !full);
  assert_no_pop_when_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> !empty);
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> empty);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int BCW = 12,
  parameter int TRIG_RESET = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = BCW + 6
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           ctrlWrEn,
  input  logic [3:0]     ctrlWrData,
  input  logic           modeWrEn,
  input  logic [9:0]     modeWrData,
  input  logic           trigWrEn,
  input  logic [CW-1:0]  trigWrData,
  input  logic           toutWrEn,
  input  logic [7:0]     toutWrData,
  input  logic [BCW-1:0] bitClocks,
  input  logic           rxValid,
  input  logic [7:0]     rxData,
  input  logic           rxBreak,
  input  logic           txWrEn,
  input  logic [7:0]     txWrData,
  input  logic           rdEn,
  input  logic [7:0]     headByte,
  input  logic [CW-1:0]  count,
  input  logic           full,
  input  logic           empty,
  output qStrobe_t       stb,
  output logic [7:0]     rdData,
  output logic           trigger,
  output logic           overrunPulse,
  output logic           timeoutPulse
);
  logic          rxOn, rxOff, active;
  logic [9:0]    modeReg;
  logic [CW-1:0] trigLevel;
  logic [7:0]    toutReg;
  logic [TW-1:0] timer, loadVal;
  logic [3:0]    dataBits, charBits;
  logic          parityBit, twoStop, rxPath, loopPath, pushReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxOn      <= 1'b0;
      rxOff     <= 1'b1;
      modeReg   <= '0;
      trigLevel <= CW'(TRIG_RESET);
      toutReg   <= '0;
    end else begin
      if (ctrlWrEn) begin
        rxOn  <= ctrlWrData[2];
        rxOff <= ctrlWrData[3];
      end
      if (modeWrEn) modeReg   <= modeWrData;
      if (trigWrEn) trigLevel <= trigWrData;
      if (toutWrEn) toutReg   <= toutWrData;
    end
  end

  assign active   = rxOn & ~rxOff;
  assign rxPath   = (modeReg[9:8] == 2'd0) || (modeReg[9:8] == 2'd1);
  assign loopPath = (modeReg[9:8] == 2'd2);
  assign pushReq  = rxBreak | (rxPath & rxValid) | (loopPath & txWrEn);

  always_comb begin
    stb.flush    = ctrlWrEn & ctrlWrData[0];
    stb.push     = active & pushReq & ~full;
    stb.pop      = active & rdEn & ~empty;
    stb.pushByte = rxBreak ? 8'h00 : (loopPath ? txWrData : rxData);
  end

  assign rdData  = (active && !empty) ? headByte : 8'h00;
  assign trigger = (count >= trigLevel);

  // Frame length in bits, from the mode word
  always_comb begin
    case (modeReg[2:1])
      2'd3:    dataBits = 4'd6;
      2'd2:    dataBits = 4'd7;
      default: dataBits = 4'd8;
    endcase
    parityBit = (modeReg[5:3] == 3'd0) || (modeReg[5:3] == 3'd1);
    twoStop   = (modeReg[7:6] != 2'd3);
    charBits  = 4'd1 + dataBits + {3'd0, parityBit} + (twoStop ? 4'd2 : 4'd1);
    loadVal   = TW'(bitClocks) * TW'(charBits) * TW'(4);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer        <= '0;
      timeoutPulse <= 1'b0;
      overrunPulse <= 1'b0;
    end else begin
      overrunPulse <= active & pushReq & full;
      timeoutPulse <= !stb.flush && !stb.push && (timer == TW'(1)) && (toutReg != 8'd0);
      if (stb.flush)          timer <= '0;
      else if (stb.push)      timer <= loadVal;
      else if (timer != '0)   timer <= timer - TW'(1);
    end
  end

  assert_overrun_only_when_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse |-> $past(full));
  assert_timeout_needs_armed_R10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> $past(toutReg) != 8'd0);
  assert_timeout_timer_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> timer == '0);
  assert_gated_activity_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push || stb.pop) |-> active);
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int BCW = 12,
  parameter int TRIG_RESET = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           ctrlWrEn,
  input  logic [3:0]     ctrlWrData,
  input  logic           modeWrEn,
  input  logic [9:0]     modeWrData,
  input  logic           trigWrEn,
  input  logic [CW-1:0]  trigWrData,
  input  logic           toutWrEn,
  input  logic [7:0]     toutWrData,
  input  logic [BCW-1:0] bitClocks,
  input  logic           rxValid,
  input  logic [7:0]     rxData,
  input  logic           rxBreak,
  input  logic           txWrEn,
  input  logic [7:0]     txWrData,
  input  logic           rdEn,
  output logic [7:0]     rdData,
  output logic [CW-1:0]  count,
  output logic           empty,
  output logic           full,
  output logic           trigger,
  output logic           overrunPulse,
  output logic           timeoutPulse
);
  qStrobe_t   stb;
  logic [7:0] headByte;

  rxq_ctrl #(.DEPTH(DEPTH), .BCW(BCW), .TRIG_RESET(TRIG_RESET)) ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .trigWrEn(trigWrEn), .trigWrData(trigWrData),
    .toutWrEn(toutWrEn), .toutWrData(toutWrData),
    .bitClocks(bitClocks),
    .rxValid(rxValid), .rxData(rxData), .rxBreak(rxBreak),
    .txWrEn(txWrEn), .txWrData(txWrData), .rdEn(rdEn),
    .headByte(headByte), .count(count), .full(full), .empty(empty),
    .stb(stb), .rdData(rdData), .trigger(trigger),
    .overrunPulse(overrunPulse), .timeoutPulse(timeoutPulse)
  );

  rxq_datapath #(.DEPTH(DEPTH)) data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .headByte(headByte), .count(count), .full(full), .empty(empty)
  );
endmodule

// File: tb/uart_rx_queue_test.sv
module uart_rx_queue_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 0, modeWrEn = 0, trigWrEn = 0, toutWrEn = 0;
  logic [3:0] ctrlWrData = 0;
  logic [9:0] modeWrData = 0;
  logic [6:0] trigWrData = 0;
  logic [7:0] toutWrData = 0;
  logic [11:0] bitClocks = 12'd1;
  logic rxValid = 0, rxBreak = 0, txWrEn = 0, rdEn = 0;
  logic [7:0] rxData = 0, txWrData = 0;
  logic [7:0] rdData;
  logic [6:0] count;
  logic empty, full, trigger, overrunPulse, timeoutPulse;

  int checks = 0, errors = 0;
  bit done = 0;
  bit benchActive = 0;
  int trigModel = 32;
  logic [7:0] q[$];

  always #2.5 clk = ~clk;

  uart_rx_queue uut (
    .clk(clk), .rstN(rstN),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .trigWrEn(trigWrEn), .trigWrData(trigWrData),
    .toutWrEn(toutWrEn), .toutWrData(toutWrData),
    .bitClocks(bitClocks),
    .rxValid(rxValid), .rxData(rxData), .rxBreak(rxBreak),
    .txWrEn(txWrEn), .txWrData(txWrData), .rdEn(rdEn),
    .rdData(rdData), .count(count), .empty(empty), .full(full),
    .trigger(trigger), .overrunPulse(overrunPulse), .timeoutPulse(timeoutPulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int expRd();
    return (benchActive && q.size() > 0) ? int'(q[0]) : 0;
  endfunction

  task automatic checkFlags(input string tag);
    chk({tag, " count R3"}, int'(count), q.size());
    chk({tag, " full R3"}, int'(full), int'(q.size() == 64));
    chk({tag, " empty R3"}, int'(empty), int'(q.size() == 0));
    chk({tag, " trigger R6"}, int'(trigger), int'(q.size() >= trigModel));
  endtask

  // one cycle in a receiver-fed mode; model updated from pre-edge state
  task automatic rxCycle(input logic v, input logic [7:0] d, input logic rd, input string tag);
    bit doPush, doPop, ovr;
    rxValid = v; rxData = d; rdEn = rd;
    #1;
    chk({tag, " rdData R5"}, int'(rdData), expRd());
    doPush = benchActive && v && q.size() < 64;
    ovr    = benchActive && v && q.size() == 64;
    doPop  = benchActive && rd && q.size() > 0;
    tick();
    if (doPop) void'(q.pop_front());
    if (doPush) q.push_back(d);
    rxValid = 0; rdEn = 0;
    chk({tag, " overrun R4"}, int'(overrunPulse), int'(ovr));
    checkFlags(tag);
  endtask

  task automatic wrCtrl(input logic [3:0] v);
    ctrlWrEn = 1; ctrlWrData = v;
    tick();
    ctrlWrEn = 0;
    benchActive = v[2] && !v[3];
    if (v[0]) q.delete();
  endtask

  task automatic wrMode(input logic [9:0] v);
    modeWrEn = 1; modeWrData = v; tick(); modeWrEn = 0;
  endtask

  task automatic wrTout(input logic [7:0] v);
    toutWrEn = 1; toutWrData = v; tick(); toutWrEn = 0;
  endtask

  // push one byte, then idle, expecting the pulse exactly at idle cycle due
  task automatic timeoutRun(input int due, input bit armed, input string tag);
    rxCycle(1, 8'h5A, 0, tag);
    for (int j = 1; j <= due + 2; j++) begin
      rxCycle(0, 0, 0, tag);
      chk({tag, " timeout R10 R11"}, int'(timeoutPulse), int'(armed && j == due));
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("reset count R1", int'(count), 0);
    chk("reset empty R1", int'(empty), 1);
    chk("reset full R1", int'(full), 0);
    chk("reset trigger R1", int'(trigger), 0);
    chk("reset pulses R1", int'(overrunPulse | timeoutPulse), 0);
    // R2 pushes ignored while off (reset state, then enable+disable both set)
    rxCycle(1, 8'h11, 0, "off push R2");
    wrCtrl(4'b1100);
    rxCycle(1, 8'h22, 1, "en+dis push R2");
    chk("gated count R2", int'(count), 0);
    wrCtrl(4'b0100);
    // fill to full, trigger crossing at 32
    for (int i = 0; i < 64; i++) rxCycle(1, 8'(i + 3), 0, "fill R3");
    chk("full after 64 R3", int'(full), 1);
    rxCycle(1, 8'hEE, 0, "overflow R4");
    chk("overflow count R4", int'(count), 64);
    // R2 pops ignored while disabled
    wrCtrl(4'b1100);
    rxCycle(0, 0, 1, "disabled pop R2");
    chk("disabled pop count R2", int'(count), 64);
    chk("disabled rdData R2", int'(rdData), 0);
    wrCtrl(4'b0100);
    for (int i = 0; i < 64; i++) rxCycle(0, 0, 1, "drain order R3");
    rxCycle(0, 0, 1, "empty pop R5");
    chk("empty rdData R5", int'(rdData), 0);
    // random traffic with changing thresholds
    for (int i = 0; i < 3000; i++) begin
      if (i % 300 == 0) begin
        trigModel = $urandom_range(0, 64);
        trigWrEn = 1; trigWrData = 7'(trigModel); tick(); trigWrEn = 0;
      end
      rxCycle(1'($urandom_range(0, 99) < (i < 1500 ? 70 : 40)), 8'($urandom),
              1'($urandom_range(0, 1)), "random R3 R6");
    end
    // R7 flush, then normal pushes resume
    for (int i = 0; i < 5; i++) rxCycle(1, 8'(i), 0, "pre flush R7");
    wrCtrl(4'b0101);
    chk("flush count R7", int'(count), 0);
    rxCycle(1, 8'h77, 0, "after flush R7");
    wrCtrl(4'b0100);
    chk("no second flush R7", int'(count), 1);
    chk("head after flush R7", int'(rdData), 8'h77);
    wrCtrl(4'b0101);
    // R8 mode 2: transmit writes enter, receiver ignored
    wrMode(10'h200);
    rxValid = 1; rxData = 8'h31; tick(); rxValid = 0;
    chk("mode2 rx ignored R8", int'(count), 0);
    txWrEn = 1; txWrData = 8'hC3; tick(); txWrEn = 0;
    chk("mode2 tx count R8", int'(count), 1);
    chk("mode2 tx data R8", int'(rdData), 8'hC3);
    // R8 mode 3: neither source
    wrMode(10'h300);
    rxValid = 1; txWrEn = 1; tick(); rxValid = 0; txWrEn = 0;
    chk("mode3 ignored R8", int'(count), 1);
    // R9 break stores zero
    rxBreak = 1; tick(); rxBreak = 0;
    chk("break count R9", int'(count), 2);
    rdEn = 1; tick(); rdEn = 0;
    chk("break byte R9", int'(rdData), 0);
    chk("break popped R9", int'(count), 1);
    // R8 mode 1 (echo) takes the receiver
    wrMode(10'h100);
    rxValid = 1; rxData = 8'h44; tick(); rxValid = 0;
    chk("mode1 rx R8", int'(count), 2);
    wrCtrl(4'b0101);
    wrMode(10'h000);
    trigModel = 32; trigWrEn = 1; trigWrData = 7'd32; tick(); trigWrEn = 0;
    // R10: disarmed, then 12-bit frames with bitClocks 1 -> 48
    bitClocks = 12'd1;
    timeoutRun(48, 0, "disarmed");
    wrTout(8'd5);
    timeoutRun(48, 1, "frame12");
    // R11: 6 data, no parity, 1 stop = 8 bits, bitClocks 2 -> 64
    wrMode(10'd230);
    bitClocks = 12'd2;
    timeoutRun(64, 1, "frame8");
    // restart: second push at idle 30 resets the window
    rxCycle(1, 8'h01, 0, "restart R10");
    for (int j = 1; j <= 30; j++) begin
      rxCycle(0, 0, 0, "restart R10");
      chk("restart early R10", int'(timeoutPulse), 0);
    end
    timeoutRun(64, 1, "restart2");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule